// File: doc/BRIEF.md
# NAND Flash Bus Cycle Engine

This block performs one bus cycle at a time on an 8-bit NAND flash interface: a command byte, an address byte, a data byte written, or a data byte read. A requester presents the cycle kind and byte with a valid flag. The engine then runs three phases, each with its own length taken from a 3-bit programmable count. In the setup phase the latch line (command or address) leads the strobe. In the strobe phase the write or read strobe is active. In the hold phase the strobe is released and the latch line and bus stay put. Read data is captured on the final clock of the strobe phase.

Two further controls act outside the cycle engine. A control bit drives the chip-enable pin directly. A ready/busy watcher synchronises the flash busy pin, reports its level, and raises a sticky flag on a selectable transition. The flag is cleared by pulsing a clear input. A global enable input gates whether new cycles are accepted.

Top module: `nandBusEngine`

## Requirements
- R1: After reset busy and done are 0, nWE and nRE are high, CLE and ALE are low, the bus is not driven, and the ready/busy flag is 0.
- R2: A cycle starts with a setup phase of exactly cfgSetup clocks, during which the latch line is active and both strobes are high. cfgSetup = 0 gives no setup clock at all.
- R3: The strobe (nWE for kinds 0..2, nRE for kind 3) is low for exactly cfgStrobe+1 consecutive clocks.
- R4: After the strobe rises, a hold phase of exactly cfgHold+1 clocks follows, with the latch line and bus drive unchanged.
- R5: busy is high from the clock after acceptance until the hold phase ends. In the next clock busy is 0 and done is 1 for exactly one clock.
- R6: reqKind encoding: 0 command (CLE active), 1 address (ALE active), 2 write data (no latch line), 3 read data (nRE strobe, bus not driven). For kinds 0..2, nandIoOe is 1 and nandIoOut carries the byte throughout the cycle. nWE and nRE are never low together.
- R7: For a read, rdByte holds the value of nandIoIn sampled at the clock edge that ends the last strobe clock.
- R8: While cfgEnable is 0, requests are not accepted: busy stays 0 and no strobe occurs.
- R9: nandCeN follows cfgCeHigh: 0 drives the pin low, 1 drives it high.
- R10: rbLevel equals nandRbIn delayed by a two-flop synchroniser. A change before a clock edge shows after the second edge.
- R11: With cfgRbEdgeFall = 0, a low-to-high transition of the synchronised busy pin sets rbFlag, and a high-to-low transition does not.
- R12: With cfgRbEdgeFall = 1, a high-to-low transition sets rbFlag, and a low-to-high transition does not.
- R13: rbFlag stays set until rbFlagClr is 1 at a clock edge. A detected transition in the same clock wins over the clear.
- R14: Kind and byte are latched at acceptance. Requests and request changes while busy have no effect on the running cycle, and they start no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Accept new cycles when 1 |
| cfgCeHigh | input | 1 | Chip-enable pin level (0 selects the device) |
| cfgSetup | input | 3 | Setup phase length in clocks |
| cfgStrobe | input | 3 | Strobe phase length minus one |
| cfgHold | input | 3 | Hold phase length minus one |
| cfgRbEdgeFall | input | 1 | Flag edge select: 0 rising, 1 falling |
| reqValid | input | 1 | Cycle request |
| reqKind | input | 2 | Cycle kind (see R6) |
| reqByte | input | 8 | Byte for command, address or write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdByte | output | 8 | Last byte read |
| rbFlagClr | input | 1 | Clear the transition flag when 1 |
| rbFlag | output | 1 | Sticky ready/busy transition flag |
| rbLevel | output | 1 | Synchronised ready/busy level |
| nandCeN | output | 1 | Flash chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Bus value when driven |
| nandIoOe | output | 1 | Bus output enable |
| nandIoIn | input | 8 | Bus value from the flash |
| nandRbIn | input | 1 | Flash ready/busy pin |

## Verification
The hardest case to reach from the ports is a request that stays valid while a cycle runs and changes its kind and byte in the middle. The engine must ignore it and still leave no second cycle behind at the done clock. The bench holds the request high with altered contents through the whole cycle and drops it only on the last hold clock. It then checks that the bus kept the original byte and latch line, and that busy stays low after done. Read capture timing is checked by having the bench flip nandIoIn to a different value as soon as nRE rises, so a capture one clock late would return the wrong byte.

// File: rtl/nandBusPkg.sv
package nandBusPkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_READ  = 2'd3
  } cycleKindT;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic  load;     // request accepted this clock
    logic  capture;  // last clock of the strobe phase
    phaseT phase;    // current phase (registered)
  } ctrlStrobeT;

endpackage

// File: rtl/nandBusCtrl.sv
module nandBusCtrl
  import nandBusPkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             cfgEnable,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic [CNT_W-1:0] heldStrobe,
  input  logic [CNT_W-1:0] heldHold,
  output ctrlStrobeT       strobes,
  output logic             busy,
  output logic             done
);

  phaseT            phase;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             lastClk;

  assign accept  = reqValid && cfgEnable && (phase == PH_IDLE);
  assign lastClk = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (cfgSetup != '0) begin
              phase <= PH_SETUP;
              cnt   <= cfgSetup - 1'b1;
            end else begin
              phase <= PH_STROBE;
              cnt   <= cfgStrobe;
            end
          end
        end
        PH_SETUP: begin
          if (lastClk) begin
            phase <= PH_STROBE;
            cnt   <= heldStrobe;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (lastClk) begin
            phase <= PH_HOLD;
            cnt   <= heldHold;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lastClk) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy            = (phase != PH_IDLE);
  assign strobes.load    = accept;
  assign strobes.capture = (phase == PH_STROBE) && lastClk;
  assign strobes.phase   = phase;

endmodule

// File: rtl/nandRbWatch.sv
module nandRbWatch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rbIn,
  input  logic edgeFall,
  input  logic flagClr,
  output logic level,
  output logic flag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevLevel;
  logic          hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '1;
      prevLevel <= 1'b1;
      flag      <= 1'b0;
    end else begin
      syncQ     <= {syncQ[LAST-1:0], rbIn};
      prevLevel <= syncQ[LAST];
      if (hit)          flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;
    end
  end

  assign level = syncQ[LAST];
  assign hit   = edgeFall ? (prevLevel && !level) : (!prevLevel && level);

endmodule

// File: rtl/nandBusDatapath.sv
module nandBusDatapath
  import nandBusPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqByte,
  input  logic [CNT_W-1:0]  cfgStrobe,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic              cfgRbEdgeFall,
  input  logic              rbFlagClr,
  input  logic [DATA_W-1:0] nandIoIn,
  input  logic              nandRbIn,
  output logic [CNT_W-1:0]  heldStrobe,
  output logic [CNT_W-1:0]  heldHold,
  output logic [DATA_W-1:0] rdByte,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandIoOut,
  output logic              nandIoOe,
  output logic              rbFlag,
  output logic              rbLevel
);

  cycleKindT         heldKind;
  logic [DATA_W-1:0] heldByte;
  logic              inCycle;
  logic              inStrobe;
  logic              isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldKind   <= KIND_CMD;
      heldByte   <= '0;
      heldStrobe <= '0;
      heldHold   <= '0;
      rdByte     <= '0;
    end else begin
      if (strobes.load) begin
        heldKind   <= cycleKindT'(reqKind);
        heldByte   <= reqByte;
        heldStrobe <= cfgStrobe;
        heldHold   <= cfgHold;
      end
      if (strobes.capture && isRead) rdByte <= nandIoIn;
    end
  end

  assign inCycle   = (strobes.phase != PH_IDLE);
  assign inStrobe  = (strobes.phase == PH_STROBE);
  assign isRead    = (heldKind == KIND_READ);

  assign nandCle   = inCycle && (heldKind == KIND_CMD);
  assign nandAle   = inCycle && (heldKind == KIND_ADDR);
  assign nandWeN   = !(inStrobe && !isRead);
  assign nandReN   = !(inStrobe && isRead);
  assign nandIoOe  = inCycle && !isRead;
  assign nandIoOut = nandIoOe ? heldByte : '0;

  nandRbWatch #(.SYNC_STAGES(SYNC_STAGES)) rbWatch (
    .clk     (clk),
    .rstN    (rstN),
    .rbIn    (nandRbIn),
    .edgeFall(cfgRbEdgeFall),
    .flagClr (rbFlagClr),
    .level   (rbLevel),
    .flag    (rbFlag)
  );

endmodule

// File: rtl/nandBusEngine.sv
module nandBusEngine
  import nandBusPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgCeHigh,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgStrobe,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic              cfgRbEdgeFall,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqByte,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdByte,
  input  logic              rbFlagClr,
  output logic              rbFlag,
  output logic              rbLevel,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandIoOut,
  output logic              nandIoOe,
  input  logic [DATA_W-1:0] nandIoIn,
  input  logic              nandRbIn
);

  ctrlStrobeT       strobes;
  logic [CNT_W-1:0] heldStrobe;
  logic [CNT_W-1:0] heldHold;

  assign nandCeN = cfgCeHigh;

  nandBusCtrl #(.CNT_W(CNT_W)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .cfgEnable (cfgEnable),
    .cfgSetup  (cfgSetup),
    .cfgStrobe (cfgStrobe),
    .heldStrobe(heldStrobe),
    .heldHold  (heldHold),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done)
  );

  nandBusDatapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqKind      (reqKind),
    .reqByte      (reqByte),
    .cfgStrobe    (cfgStrobe),
    .cfgHold      (cfgHold),
    .cfgRbEdgeFall(cfgRbEdgeFall),
    .rbFlagClr    (rbFlagClr),
    .nandIoIn     (nandIoIn),
    .nandRbIn     (nandRbIn),
    .heldStrobe   (heldStrobe),
    .heldHold     (heldHold),
    .rdByte       (rdByte),
    .nandCle      (nandCle),
    .nandAle      (nandAle),
    .nandWeN      (nandWeN),
    .nandReN      (nandReN),
    .nandIoOut    (nandIoOut),
    .nandIoOe     (nandIoOe),
    .rbFlag       (rbFlag),
    .rbLevel      (rbLevel)
  );

endmodule

// File: rtl/nandBusEngineChk.sv
module nandBusEngineChk (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic busy,
  input logic done,
  input logic rbFlag,
  input logic rbFlagClr,
  input logic nandCle,
  input logic nandAle,
  input logic nandWeN,
  input logic nandReN,
  input logic nandIoOe
);

  // R6: the two strobes are never low together
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R6: the bus is never driven while the read strobe is low
  p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(nandIoOe && !nandReN));

  // R3: a strobe only occurs inside a busy cycle
  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> busy);

  // R6: CLE and ALE are never active together
  p_latch_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  // R5: done follows a busy clock and lasts one clock
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: disabled idle engine stays idle
  p_no_accept_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgEnable) |=> !busy);

  // R13: flag is sticky without a clear
  p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    (rbFlag && !rbFlagClr) |=> rbFlag);

endmodule

bind nandBusEngine nandBusEngineChk chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgEnable(cfgEnable),
  .busy     (busy),
  .done     (done),
  .rbFlag   (rbFlag),
  .rbFlagClr(rbFlagClr),
  .nandCle  (nandCle),
  .nandAle  (nandAle),
  .nandWeN  (nandWeN),
  .nandReN  (nandReN),
  .nandIoOe (nandIoOe)
);

// File: tb/nandBusEngine_test.sv
`timescale 1ns/1ps
module nandBusEngine_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEnable = 1'b1;
  logic       cfgCeHigh = 1'b1;
  logic [2:0] cfgSetup = '0;
  logic [2:0] cfgStrobe = '0;
  logic [2:0] cfgHold = '0;
  logic       cfgRbEdgeFall = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic [7:0] reqByte = '0;
  logic       busy, done, rbFlag, rbLevel;
  logic [7:0] rdByte;
  logic       rbFlagClr = 1'b0;
  logic       nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0] nandIoOut;
  logic [7:0] nandIoIn = '0;
  logic       nandRbIn = 1'b1;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  nandBusEngine uut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCeHigh(cfgCeHigh),
    .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .cfgRbEdgeFall(cfgRbEdgeFall), .reqValid(reqValid), .reqKind(reqKind),
    .reqByte(reqByte), .busy(busy), .done(done), .rdByte(rdByte),
    .rbFlagClr(rbFlagClr), .rbFlag(rbFlag), .rbLevel(rbLevel),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .nandIoIn(nandIoIn), .nandRbIn(nandRbIn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  task automatic waitClocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One full bus cycle, sampled at every falling edge
  task automatic runCycle(input logic [1:0] kind, input logic [7:0] b,
                          input int s, input int t, input int h,
                          input bit keepReq, input string tag);
    int setupSeen = 0, strobeSeen = 0, holdSeen = 0;
    int latchBad = 0, busBad = 0;
    bit strobeNow;
    cfgSetup = 3'(s); cfgStrobe = 3'(t); cfgHold = 3'(h);
    reqKind = kind; reqByte = b; reqValid = 1'b1; nandIoIn = ~b;
    @(posedge clk);
    @(negedge clk);
    if (keepReq) begin
      reqByte = ~b;
      reqKind = kind ^ 2'b01;
    end else begin
      reqValid = 1'b0;
    end
    for (int i = 0; i < 64 && busy; i++) begin
      strobeNow = !nandWeN || !nandReN;
      if (strobeNow) strobeSeen++;
      else if (strobeSeen == 0) setupSeen++;
      else holdSeen++;
      if (nandCle != (kind == 2'd0) || nandAle != (kind == 2'd1)) latchBad++;
      if (strobeNow && ((kind == 2'd3) == nandReN)) busBad++;
      if (nandIoOe != (kind != 2'd3)) busBad++;
      if (kind != 2'd3 && nandIoOut != b) busBad++;
      nandIoIn = !nandReN ? b : ~b;
      if (keepReq && holdSeen == h + 1) reqValid = 1'b0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(setupSeen == s, {tag, " R2 setup clocks"}, setupSeen, s);
    check(strobeSeen == t + 1, {tag, " R3 strobe clocks"}, strobeSeen, t + 1);
    check(holdSeen == h + 1, {tag, " R4 hold clocks"}, holdSeen, h + 1);
    check(latchBad == 0, {tag, " R6 latch lines"}, latchBad, 0);
    check(busBad == 0, {tag, keepReq ? " R14 bus/strobe kept" : " R6 bus/strobe"},
          busBad, 0);
    check(done == 1'b1 && busy == 1'b0, {tag, " R5 done pulse"}, int'(done), 1);
    if (kind == 2'd3) check(rdByte == b, {tag, " R7 read capture"}, int'(rdByte), int'(b));
    @(negedge clk);
    check(done == 1'b0, {tag, " R5 done one clock"}, int'(done), 0);
    check(busy == 1'b0, {tag, " R14 no extra cycle"}, int'(busy), 0);
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0, "R1 busy/done after reset", int'({busy, done}), 0);
    check(nandWeN && nandReN, "R1 strobes high", int'({nandWeN, nandReN}), 3);
    check(!nandCle && !nandAle && !nandIoOe, "R1 latches/bus idle",
          int'({nandCle, nandAle, nandIoOe}), 0);
    check(rbFlag == 0, "R1 flag clear", int'(rbFlag), 0);
  endtask

  task automatic testDisabled();
    int bad = 0;
    cfgEnable = 1'b0;
    reqKind = 2'd2; reqByte = 8'h3C; reqValid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || !nandWeN || !nandReN) bad++;
    end
    reqValid = 1'b0;
    check(bad == 0, "R8 disabled ignores request", bad, 0);
    cfgEnable = 1'b1;
    @(negedge clk);
    check(busy == 0, "R8 stale request not taken later", int'(busy), 0);
  endtask

  task automatic testChipEnable();
    cfgCeHigh = 1'b0; #1;
    check(nandCeN == 1'b0, "R9 ce low", int'(nandCeN), 0);
    cfgCeHigh = 1'b1; #1;
    check(nandCeN == 1'b1, "R9 ce high", int'(nandCeN), 1);
    cfgCeHigh = 1'b0;
  endtask

  task automatic clearFlag();
    rbFlagClr = 1'b1;
    @(negedge clk);
    rbFlagClr = 1'b0;
  endtask

  task automatic testRbRise();
    cfgRbEdgeFall = 1'b0;
    waitClocks(2);
    clearFlag();
    nandRbIn = 1'b0;
    @(negedge clk);
    check(rbLevel == 1'b1, "R10 level after one edge", int'(rbLevel), 1);
    @(negedge clk);
    check(rbLevel == 1'b0, "R10 level after two edges", int'(rbLevel), 0);
    waitClocks(4);
    check(rbFlag == 1'b0, "R11 fall ignored in rise mode", int'(rbFlag), 0);
    nandRbIn = 1'b1;
    waitClocks(4);
    check(rbFlag == 1'b1, "R11 rise sets flag", int'(rbFlag), 1);
    waitClocks(5);
    check(rbFlag == 1'b1, "R13 flag sticky", int'(rbFlag), 1);
    clearFlag();
    check(rbFlag == 1'b0, "R13 write 1 clears", int'(rbFlag), 0);
  endtask

  task automatic testRbFall();
    cfgRbEdgeFall = 1'b1;
    waitClocks(2);
    clearFlag();
    nandRbIn = 1'b0;
    waitClocks(4);
    check(rbFlag == 1'b1, "R12 fall sets flag", int'(rbFlag), 1);
    clearFlag();
    nandRbIn = 1'b1;
    waitClocks(4);
    check(rbFlag == 1'b0, "R12 rise ignored in fall mode", int'(rbFlag), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    failCount++;
    checkCount++;
    $display("FAIL R5 watchdog expired actual=hung expected=finish");
    finishRun();
  end

  initial begin
    waitClocks(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChipEnable();
    runCycle(2'd0, 8'h70, 2, 1, 0, 1'b0, "cmd");
    runCycle(2'd1, 8'h5A, 0, 0, 2, 1'b0, "addr zero setup");
    runCycle(2'd2, 8'hC3, 7, 7, 7, 1'b0, "write max");
    runCycle(2'd3, 8'hA5, 1, 3, 1, 1'b0, "read");
    runCycle(2'd3, 8'h0F, 0, 0, 0, 1'b0, "read min");
    runCycle(2'd2, 8'h96, 1, 2, 2, 1'b1, "held request");
    testDisabled();
    testRbRise();
    testRbFall();
    finishRun();
  end

endmodule